// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps transitions on a small set of input pins. A free-running capture counter advances once every `prescale + 1` clock cycles while a global enable is set. Each pin has its own edge-mode field: off, rising, falling or any edge. When a transition of the selected kind is seen on a pin, the channel copies the counter into its capture register and sets that channel's status bit. The status bit can be routed to a single interrupt line through a per-channel enable mask. Software clears it by writing ones to an acknowledge register.

Software measures a pulse's high time by capturing a rising edge, then switching the mode to falling and capturing again. The low time is measured the same way with the order reversed. Each pin passes through a two-flop synchroniser before edge detection, so the pins may be asynchronous to the clock.

Top module: `icu_top`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: The edge mode of channel n is held in bits 1:0 at offset 0x30+4n: 0 captures nothing, 1 captures rising edges, 2 captures falling edges, 3 captures both.
- R3: The counter value taken at a capture is read at offset 0x10+4n. Two captures whose synchronised edges are D cycles apart differ by D when the prescaler is 0.
- R4: The control register at 0x50 has the global enable in bit 10 and a 5-bit prescaler p in bits 8:4. While enabled, the counter advances once every p+1 cycles, so edges k(p+1) cycles apart give captures that differ by k.
- R5: While the global enable is clear, the counter holds its value and no channel captures or sets status.
- R6: A capture on channel n sets bit n+1 of the status register at 0x58. The bit stays set until it is acknowledged.
- R7: A write to 0x5C clears each status bit whose position in the written data is 1. Status bits written as 0 are unaffected.
- R8: If a capture and an acknowledge of the same status bit fall in the same cycle, the bit stays set.
- R9: The interrupt enable bits for channel n sit at bit n+1 of offset 0x54. `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R10: A channel in mode 0 leaves its capture register and status bit unchanged whatever its pin does.
- R11: An edge on one pin affects only that channel's capture register and status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_in | input | NCH | Capture pins, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | OR over channels of status AND enable |

## Verification
A pin change driven between clock edges reaches the second synchroniser flop after two rising edges. The edge is detected in the following cycle, and the capture register and status bit update on the third edge. The bench therefore waits at least three edges after a pin change before it reads anything back. The same-cycle acknowledge test drives the acknowledge write in the cycle between the second and third edges, so it lands on the capture edge exactly. Reads are combinational and are sampled after a falling edge. Counter values are checked only as differences between two captures, with edge spacings counted in whole cycles, so the synchroniser latency cancels.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int PS_W   = 5;

    localparam logic [ADDR_W-1:0] OFS_VAL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_STS  = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h5C;

    localparam int CTRL_RUN_BIT = 10;
    localparam int CTRL_PS_LSB  = 4;
    localparam int FLAG_LSB     = 1;

    typedef enum logic [1:0] {
        EDG_OFF  = 2'd0,
        EDG_RISE = 2'd1,
        EDG_FALL = 2'd2,
        EDG_ANY  = 2'd3
    } edge_mode_e;

    typedef struct packed {
        logic            run;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    function automatic logic edge_hit(edge_mode_e m, logic rise, logic fall);
        case (m)
            EDG_RISE: return rise;
            EDG_FALL: return fall;
            EDG_ANY:  return rise | fall;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] chan_addr(logic [ADDR_W-1:0] base, int n);
        return base + ADDR_W'(4 * n);
    endfunction

endpackage

// File: rtl/icu_timebase.sv
module icu_timebase
    import icu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PS_W-1:0]  ps,
    output logic [CNT_W-1:0] stamp
);
    logic [PS_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            stamp <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (div_q >= ps) begin
            div_q <= '0;
            stamp <= stamp + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(stamp)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        run |=> (stamp == $past(stamp)) || (stamp == $past(stamp) + 1'b1)); // R4

endmodule

// File: rtl/icu_channel.sv
module icu_channel
    import icu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin,
    input  edge_mode_e       mode,
    input  logic             run,
    input  logic [CNT_W-1:0] stamp,
    output logic             hit,
    output logic [CNT_W-1:0] cap_val
);
    logic [2:0] sh_q;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], pin};
    end

    assign rise = sh_q[1] & ~sh_q[2];
    assign fall = ~sh_q[1] & sh_q[2];
    assign hit  = run & edge_hit(mode, rise, fall);

    always_ff @(posedge clk) begin
        if (rst)      cap_val <= '0;
        else if (hit) cap_val <= stamp;
    end

    AST_OFF_NO_CAP: assert property (@(posedge clk) disable iff (rst)
        (mode == EDG_OFF) |=> $stable(cap_val)); // R10

    AST_STOPPED_NO_CAP: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(cap_val)); // R5

endmodule

// File: rtl/icu_top.sv
module icu_top
    import icu_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cap_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int FLAG_MSB = FLAG_LSB + NCH - 1;

    ctrl_t            ctrl_q;
    logic [NCH-1:0]   ien_q, sts_q, hit, ack_bits;
    edge_mode_e       mode_q [NCH];
    logic [CNT_W-1:0] cap_val [NCH];
    logic [CNT_W-1:0] stamp;

    initial begin
        if (NCH > 4 || NCH < 1) $error("NCH out of range");
        if (CNT_W > DATA_W)     $error("CNT_W too wide");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFS_CTRL) begin
                ctrl_q.run <= reg_wdata[CTRL_RUN_BIT];
                ctrl_q.ps  <= reg_wdata[CTRL_PS_LSB +: PS_W];
            end
            if (reg_addr == OFS_IEN) ien_q <= reg_wdata[FLAG_MSB:FLAG_LSB];
        end
    end

    assign ack_bits = (reg_we && reg_addr == OFS_ACK) ? reg_wdata[FLAG_MSB:FLAG_LSB] : '0;

    icu_timebase #(.CNT_W(CNT_W)) tb_i (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .ps(ctrl_q.ps), .stamp(stamp)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [ADDR_W-1:0] MODE_A = chan_addr(OFS_MODE, n);

        always_ff @(posedge clk) begin
            if (rst)                            mode_q[n] <= EDG_OFF;
            else if (reg_we && reg_addr == MODE_A) mode_q[n] <= edge_mode_e'(reg_wdata[1:0]);
        end

        icu_channel #(.CNT_W(CNT_W)) ch_i (
            .clk(clk), .rst(rst), .pin(cap_in[n]), .mode(mode_q[n]),
            .run(ctrl_q.run), .stamp(stamp), .hit(hit[n]), .cap_val(cap_val[n])
        );

        always_ff @(posedge clk) begin
            if (rst) sts_q[n] <= 1'b0;
            else     sts_q[n] <= hit[n] | (sts_q[n] & ~ack_bits[n]);
        end

        AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (sts_q[n] && !ack_bits[n]) |=> sts_q[n]); // R6

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (ack_bits[n] && !hit[n]) |=> !sts_q[n]); // R7

        AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
            hit[n] |=> sts_q[n]); // R8
    end

    assign irq = |(sts_q & ien_q);

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq); // R9

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTRL_RUN_BIT]          = ctrl_q.run;
                reg_rdata[CTRL_PS_LSB +: PS_W]   = ctrl_q.ps;
            end
            OFS_IEN: reg_rdata[FLAG_MSB:FLAG_LSB] = ien_q;
            OFS_STS: reg_rdata[FLAG_MSB:FLAG_LSB] = sts_q;
            default: ;
        endcase
        for (int n = 0; n < NCH; n++) begin
            if (reg_addr == chan_addr(OFS_VAL, n))  reg_rdata = DATA_W'(cap_val[n]);
            if (reg_addr == chan_addr(OFS_MODE, n)) reg_rdata = DATA_W'(mode_q[n]);
        end
    end

endmodule

// File: tb/icu_top_tb_top.sv
module icu_top_tb_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cap_in = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    icu_top #(.NCH(NCH), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .cap_in(cap_in), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic pin(int ch, logic v);
        @(negedge clk); cap_in[ch] = v;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic bit rise_ok(int m); return m == 1 || m == 3; endfunction
    function automatic bit fall_ok(int m); return m == 2 || m == 3; endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a, b, v0;
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h50, d); chk("R1 ctrl", d, 0);
        rd(8'h54, d); chk("R1 ien", d, 0);
        rd(8'h58, d); chk("R1 sts", d, 0);
        for (int n = 0; n < NCH; n++) begin
            rd(8'h10 + 8'(4*n), d); chk("R1 val", d, 0);
            rd(8'h30 + 8'(4*n), d); chk("R1 mode", d, 0);
        end
        chk("R1 irq", irq, 0);

        // R5 stopped: no capture while enable is clear
        wr(8'h30, 3);
        pin(0, 1); settle(); pin(0, 0); settle();
        rd(8'h58, d); chk("R5 no status when stopped", d, 0);
        rd(8'h10, d); chk("R5 no value when stopped", d, 0);

        wr(8'h50, 32'h400);
        rd(8'h50, d); chk("R4 ctrl readback", d, 32'h400);

        // Sweep: channel x mode, R2 R6 R7 R9 R10 R11
        for (int ch = 0; ch < NCH; ch++) begin
            for (int m = 0; m < 4; m++) begin
                wr(8'h58 + 8'h4, 32'h1FF);
                wr(8'h54, 32'(1 << (ch + 1)));
                wr(8'h30 + 8'(4*ch), 32'(m));
                rd(8'h30 + 8'(4*ch), d); chk("R2 mode readback", d, m);
                rd(8'h10 + 8'(4*ch), v0);
                pin(ch, 1); settle();
                rd(8'h58, d);
                chk("R2 R6 rise status", d[ch+1], rise_ok(m));
                chk("R11 other channels", d & ~(32'(1) << (ch+1)), 0);
                chk("R9 irq follows status", irq, rise_ok(m));
                if (m == 0) begin
                    rd(8'h10 + 8'(4*ch), d); chk("R10 value unchanged", d, v0);
                end
                wr(8'h54, 0);
                chk("R9 irq masked", irq, 0);
                wr(8'h5C, 32'h1FF & ~(32'(1) << (ch+1)));
                rd(8'h58, d); chk("R7 zero bits untouched", d[ch+1], rise_ok(m));
                wr(8'h5C, 32'(1) << (ch+1));
                rd(8'h58, d); chk("R7 ack clears", d, 0);
                pin(ch, 0); settle();
                rd(8'h58, d); chk("R2 R6 fall status", d[ch+1], fall_ok(m));
                if (m == 0) begin
                    rd(8'h10 + 8'(4*ch), d); chk("R10 value unchanged", d, v0);
                end
                wr(8'h30 + 8'(4*ch), 0);
            end
        end

        // R4 prescaler sweep: ch0 rising, ch1 falling, edges 3(p+1) apart
        wr(8'h30, 1); wr(8'h34, 2);
        for (int pi = 0; pi < 6; pi++) begin
            int p;
            p = (pi == 5) ? 31 : pi * 2;
            wr(8'h50, 32'h400 | 32'(p << 4));
            rd(8'h50, d); chk("R4 ctrl readback", d, 32'h400 | 32'(p << 4));
            @(negedge clk); cap_in[1:0] = 2'b11;
            repeat (3 * (p + 1)) @(negedge clk);
            cap_in[1:0] = 2'b00;
            settle();
            rd(8'h10, a); rd(8'h14, b);
            chk("R4 prescaled difference", b - a, 3);
        end

        // R5 counter holds while disabled
        wr(8'h50, 32'h0);
        wr(8'h30, 3); wr(8'h5C, 32'h1FF);
        rd(8'h10, v0);
        pin(0, 1); settle(); pin(0, 0); settle();
        rd(8'h10, d); chk("R5 value held when stopped", d, v0);
        rd(8'h58, d); chk("R5 status clear when stopped", d, 0);

        // R3 polarity flip between captures, prescaler 0
        wr(8'h50, 32'h400);
        wr(8'h3C, 1); wr(8'h5C, 32'h1FF);
        @(negedge clk); cap_in[3] = 1'b1; t0 = cyc;
        settle();
        rd(8'h3C - 8'h20, a);
        wr(8'h5C, 32'h10);
        wr(8'h3C, 2);
        while (cyc < t0 + 40) @(negedge clk);
        cap_in[3] = 1'b0;
        settle();
        rd(8'h1C, b);
        chk("R3 high time", b - a, 40);
        rd(8'h58, d); chk("R6 status after flip", d[4], 1);

        // R8 capture and acknowledge in the same cycle
        wr(8'h38, 3); wr(8'h5C, 32'h1FF);
        pin(2, 1); settle();
        rd(8'h58, d); chk("R8 preset status", d[3], 1);
        @(negedge clk); cap_in[2] = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_we = 1'b1; reg_addr = 8'h5C; reg_wdata = 32'h8;
        @(negedge clk); reg_we = 1'b0;
        rd(8'h58, d); chk("R8 capture wins", d[3], 1);
        wr(8'h5C, 32'h8);
        rd(8'h58, d); chk("R8 later ack clears", d[3], 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule